// File: doc/BRIEF.md
# Frequency-Trimmed Nanosecond Time Counter

This block turns a free-running 32-bit raw cycle count, supplied by a neighbouring counter, into a 64-bit time value in nanoseconds. On every clock it takes the cycles elapsed since its last sample, modulo 2^32. It multiplies them by a fixed-point multiplier with 28 fractional bits and adds the whole nanoseconds to the time. The fractional nanoseconds are kept in a residue register. The nominal multiplier is the raw counter period in nanoseconds shifted left by 28. The period, 4, 8 or 10 ns, is chosen at run time by a picosecond input.

Software controls the block through a one-cycle command port with four operations. A read returns the current time. A fine adjustment sets a signed frequency correction in scaled ppm, which is parts per million times 2^16. A step adds a signed nanosecond offset. A set loads an absolute time and rebases the counter on the present raw count. The elapsed cycles are folded into the time every cycle using the multiplier in force, so a multiplier change never applies to cycles that went by before it.

Top module: `ns_time_counter`

## Requirements
- R1: Elapsed cycles are the difference of the current and previous raw count modulo 2^32, so a wrap of the raw count loses no time.
- R2: `period_ps` values 4000, 8000 and 10000 are supported. Any other value raises `cfg_err` combinationally, and from the next edge the multiplier is zero, so time stops advancing.
- R3: With no correction, each elapsed raw cycle adds exactly the period in ns, because the multiplier is period_ns × 2^28.
- R4: A correction with magnitude |s| changes the multiplier by floor(|s| × num / den). The pair (num, den) is (256, 15625) for 4 ns, (512, 15625) for 8 ns and (128, 3125) for 10 ns.
- R5: A positive correction value adds this amount to the nominal multiplier, and a negative value subtracts it.
- R6: Cycles that elapse up to and including the edge that accepts a correction are scaled by the old multiplier. The new one applies from the following edge.
- R7: A fine adjustment with |s| above 65,536,000 (1,000,000 ppb) is rejected. `adj_rej` pulses for one cycle and the multiplier is left unchanged.
- R8: A step (op 2) adds the signed 64-bit `cmd_data` to the updated time on the same edge.
- R9: A set (op 3) loads `cmd_data` as the time, clears the residue and rebases on the current raw count, so cycles since the last sample are discarded.
- R10: A read (op 0) returns the updated time of that edge on `rd_data`, with a one-cycle `rd_valid` pulse.
- R11: The low 28 bits of each product are kept and added to the next product, so fractional nanoseconds accumulate without loss.
- R12: Commands use `cmd_op` 0 = read, 1 = fine adjustment (signed value in `cmd_data[31:0]`), 2 = step, 3 = set. A fine adjustment reads only `cmd_data[31:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| raw_cnt | input | 32 | Free-running raw cycle count |
| period_ps | input | 16 | Raw counter period in picoseconds |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_op | input | 2 | Operation code |
| cmd_data | input | 64 | Command operand |
| time_ns | output | 64 | Current time in nanoseconds |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 64 | Read result |
| adj_rej | output | 1 | Fine adjustment rejected |
| cfg_err | output | 1 | Unsupported period selected |

## Verification
The embedded assertions watch properties that must hold on every cycle:
- the multiplier stays within its legal range, and is zero after an unsupported period;
- time never goes backwards except on a step or a set;
- a set lands exactly on its operand;
- a rejection leaves the correction unchanged;
- a read result follows only a read command.

The exact arithmetic can only be shown by the bench's scenarios: the wrap handling, the per-period coefficients, the sign of the correction, the old/new multiplier boundary and the carrying of the residue. The bench checks these against a reference model and against hand-computed values.

// File: rtl/ns_time_counter.sv
module ns_time_counter #(
  parameter int CNT_W    = 32,
  parameter int TIME_W   = 64,
  parameter int FRAC_W   = 28,
  parameter int MULT_W   = 33,
  parameter int MAX_SPPM = 65_536_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  raw_cnt,
  input  logic [15:0]       period_ps,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [TIME_W-1:0] cmd_data,
  output logic [TIME_W-1:0] time_ns,
  output logic              rd_valid,
  output logic [TIME_W-1:0] rd_data,
  output logic              adj_rej,
  output logic              cfg_err
);
  localparam int ACC_W = CNT_W + MULT_W + 1;
  localparam int SC_W  = 48;
  localparam logic [MULT_W-1:0] MULT_MAX = MULT_W'(64'd2_687_038_914);

  localparam logic [1:0] OP_READ = 2'd0;
  localparam logic [1:0] OP_FINE = 2'd1;
  localparam logic [1:0] OP_STEP = 2'd2;
  localparam logic [1:0] OP_SET  = 2'd3;

  function automatic logic [32:0] mag33(input logic [31:0] v);
    return v[31] ? (~{v[31], v} + 33'd1) : {1'b0, v};
  endfunction

  function automatic logic [MULT_W-1:0] mult_for(input logic [15:0] per, input logic [31:0] sp);
    logic [SC_W-1:0]   sc;
    logic [MULT_W-1:0] nom;
    logic [MULT_W-1:0] diff;
    sc = SC_W'(mag33(sp));
    case (per)
      16'd4000:  begin nom = MULT_W'(4)  << FRAC_W; diff = MULT_W'((sc << 8) / SC_W'(15625)); end
      16'd8000:  begin nom = MULT_W'(8)  << FRAC_W; diff = MULT_W'((sc << 9) / SC_W'(15625)); end
      16'd10000: begin nom = MULT_W'(10) << FRAC_W; diff = MULT_W'((sc << 7) / SC_W'(3125));  end
      default:   begin nom = '0; diff = '0; end
    endcase
    return sp[31] ? nom - diff : nom + diff;
  endfunction

  logic [CNT_W-1:0]  last_q;
  logic [FRAC_W-1:0] res_q;
  logic [MULT_W-1:0] mult_q;
  logic [31:0]       sp_q;
  logic [TIME_W-1:0] time_q;

  logic [CNT_W-1:0]  elapsed;
  logic [ACC_W-1:0]  acc;
  logic [TIME_W-1:0] t_next;
  logic              is_fine, too_big;
  logic [31:0]       sp_next;

  assign cfg_err = !(period_ps == 16'd4000 || period_ps == 16'd8000 || period_ps == 16'd10000);
  assign elapsed = raw_cnt - last_q;
  assign acc     = ACC_W'(elapsed) * ACC_W'(mult_q) + ACC_W'(res_q);
  assign t_next  = time_q + TIME_W'(acc[ACC_W-1:FRAC_W]);
  assign is_fine = cmd_valid && cmd_op == OP_FINE;
  assign too_big = mag33(cmd_data[31:0]) > 33'(MAX_SPPM);
  assign sp_next = (is_fine && !too_big) ? cmd_data[31:0] : sp_q;
  assign time_ns = time_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_q   <= raw_cnt;
      res_q    <= '0;
      mult_q   <= '0;
      sp_q     <= '0;
      time_q   <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
      adj_rej  <= 1'b0;
    end else begin
      last_q   <= raw_cnt;
      res_q    <= acc[FRAC_W-1:0];
      time_q   <= t_next;
      sp_q     <= sp_next;
      mult_q   <= mult_for(period_ps, sp_next);
      rd_valid <= 1'b0;
      adj_rej  <= is_fine && too_big;
      if (cmd_valid) begin
        case (cmd_op)
          OP_READ: begin rd_valid <= 1'b1; rd_data <= t_next; end
          OP_STEP: time_q <= t_next + cmd_data;
          OP_SET:  begin time_q <= cmd_data; res_q <= '0; end
          default: ;
        endcase
      end
    end
  end

  AST_MULT_RANGE: assert property (@(posedge clk) disable iff (!rst_n) mult_q <= MULT_MAX); // R4
  AST_CFG_STOP: assert property (@(posedge clk) disable iff (!rst_n) cfg_err |=> mult_q == '0); // R2
  AST_TIME_MONO: assert property (@(posedge clk) disable iff (!rst_n) !(cmd_valid && cmd_op[1]) |=> time_q >= $past(time_q)); // R8
  AST_SET_LOAD: assert property (@(posedge clk) disable iff (!rst_n) (cmd_valid && cmd_op == OP_SET) |=> time_q == $past(cmd_data)); // R9
  AST_REJ_HOLD: assert property (@(posedge clk) disable iff (!rst_n) adj_rej |-> sp_q == $past(sp_q)); // R7
  AST_RD_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) rd_valid |-> $past(cmd_valid && cmd_op == OP_READ)); // R10
endmodule

// File: tb/tb_ns_time_counter.sv
module tb_ns_time_counter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] raw_cnt = 32'd0;
  logic [15:0] period_ps = 16'd8000;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = 2'd0;
  logic [63:0] cmd_data = 64'd0;
  logic [63:0] time_ns, rd_data;
  logic        rd_valid, adj_rej, cfg_err;

  int errors = 0, checks = 0;
  bit mcheck = 1'b0, done = 1'b0;

  always #5 clk = ~clk;

  ns_time_counter dut (.clk, .rst_n, .raw_cnt, .period_ps, .cmd_valid, .cmd_op,
                       .cmd_data, .time_ns, .rd_valid, .rd_data, .adj_rej, .cfg_err);

  // reference model
  longint unsigned m_time, m_mult, m_rd;
  logic [27:0]     m_res;
  logic [31:0]     m_last;
  int              m_sp;
  bit              m_rdv, m_rej;

  function automatic longint unsigned ref_mult(int unsigned per, int sp);
    longint mag = sp;
    longint unsigned nom, dif;
    if (mag < 0) mag = -mag;
    if (per == 4000)       begin nom = 64'd4  * 64'd268435456; dif = (mag * 256) / 15625; end
    else if (per == 8000)  begin nom = 64'd8  * 64'd268435456; dif = (mag * 512) / 15625; end
    else if (per == 10000) begin nom = 64'd10 * 64'd268435456; dif = (mag * 128) / 3125;  end
    else return 0;
    return (sp < 0) ? nom - dif : nom + dif;
  endfunction

  function automatic bit ref_cfg_ok(int unsigned per);
    return per == 4000 || per == 8000 || per == 10000;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_time = 0; m_res = 0; m_last = raw_cnt; m_sp = 0; m_mult = 0;
      m_rd = 0; m_rdv = 0; m_rej = 0;
    end else begin
      logic [127:0] a;
      logic [31:0]  d;
      longint unsigned tn;
      longint mag;
      d  = raw_cnt - m_last;
      a  = 128'(d) * 128'(m_mult) + 128'(m_res);
      tn = m_time + 64'(a >> 28);
      m_res = a[27:0]; m_last = raw_cnt; m_time = tn; m_rdv = 0; m_rej = 0;
      if (cmd_valid) begin
        case (cmd_op)
          2'd0: begin m_rdv = 1; m_rd = tn; end
          2'd1: begin
            mag = longint'($signed(cmd_data[31:0]));
            if (mag < 0) mag = -mag;
            if (mag > 65536000) m_rej = 1; else m_sp = $signed(cmd_data[31:0]);
          end
          2'd2: m_time = tn + cmd_data;
          default: begin m_time = cmd_data; m_res = 0; end
        endcase
      end
      m_mult = ref_mult(period_ps, m_sp);
    end
  end

  task automatic chk(input bit ok, input string req, input longint unsigned act, input longint unsigned exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_cmp();
    chk(time_ns == m_time, "R4 model time", time_ns, m_time);
    chk(rd_valid == m_rdv, "R10 model rd_valid", rd_valid, m_rdv);
    if (m_rdv) chk(rd_data == m_rd, "R10 model rd_data", rd_data, m_rd);
    chk(adj_rej == m_rej, "R7 model adj_rej", adj_rej, m_rej);
    chk(cfg_err == !ref_cfg_ok(period_ps), "R2 model cfg_err", cfg_err, !ref_cfg_ok(period_ps));
  endtask

  task automatic tick(input bit v, input logic [1:0] op, input logic [63:0] dat, input logic [31:0] inc);
    @(negedge clk);
    if (mcheck) model_cmp();
    raw_cnt = raw_cnt + inc; cmd_valid = v; cmd_op = op; cmd_data = dat;
  endtask

  task automatic settle(); tick(0, 2'd0, 64'd0, 32'd0); endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    raw_cnt = 32'hFFFF_FF00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();
    chk(time_ns == 0 && !rd_valid && !adj_rej, "reset state", time_ns, 0);
    mcheck = 1'b1;
    settle(); settle();

    // R3: 8 ns nominal
    tick(1, 2'd3, 64'd0, 0);
    repeat (10) tick(0, 2'd0, 0, 1);
    settle();
    chk(time_ns == 80, "R3 nominal 8ns x10", time_ns, 80);

    // R1: raw wrap
    raw_cnt = 32'hFFFF_FFFE;
    tick(1, 2'd3, 64'd0, 0);
    tick(0, 2'd0, 0, 4);
    settle();
    chk(time_ns == 32, "R1 wrap of raw count", time_ns, 32);

    // R4/R5: 4 ns, +15625 and -15625
    period_ps = 16'd4000;
    tick(1, 2'd3, 64'd0, 0);
    tick(1, 2'd1, 64'd15625, 0);
    tick(0, 2'd0, 0, 32'd1 << 20);
    settle();
    chk(time_ns == 4194305, "R4 R5 positive correction", time_ns, 4194305);
    tick(1, 2'd3, 64'd0, 0);
    tick(1, 2'd1, {32'hFFFF_FFFF, -32'sd15625}, 0);
    tick(0, 2'd0, 0, 32'd1 << 20);
    settle();
    chk(time_ns == 4194303, "R5 negative correction", time_ns, 4194303);

    // R12: upper operand bits ignored by fine adjustment
    tick(1, 2'd3, 64'd0, 0);
    tick(1, 2'd1, {32'hDEAD_BEEF, 32'd0}, 0);
    tick(0, 2'd0, 0, 32'd1 << 20);
    settle();
    chk(time_ns == 4194304, "R12 fine uses low word only", time_ns, 4194304);

    // R11: residue carry, 4 ns with +62 -> mult 2^30+1
    tick(1, 2'd3, 64'd0, 0);
    tick(1, 2'd1, 64'd62, 0);
    tick(0, 2'd0, 0, 32'd1 << 27);
    settle();
    chk(time_ns == 536870912, "R11 first half", time_ns, 536870912);
    tick(0, 2'd0, 0, 32'd1 << 27);
    settle();
    chk(time_ns == 1073741825, "R11 residue carried", time_ns, 1073741825);

    // R6: fold-in with old multiplier at 8 ns
    period_ps = 16'd8000;
    tick(1, 2'd1, 64'd0, 0);
    tick(1, 2'd3, 64'd0, 0);
    tick(1, 2'd1, 64'd15625, 32'd1 << 20);
    tick(0, 2'd0, 0, 32'd1 << 20);
    settle();
    chk(time_ns == 16777218, "R6 old then new multiplier", time_ns, 16777218);

    // R8 step and R10 read
    tick(1, 2'd2, 64'd1000, 0);
    settle();
    chk(time_ns == 16778218, "R8 positive step", time_ns, 16778218);
    tick(1, 2'd2, -64'sd500, 0);
    tick(1, 2'd0, 0, 0);
    settle();
    chk(rd_valid && rd_data == 16777718, "R10 read after negative step R8", rd_data, 16777718);

    // R9: set discards elapsed cycles
    tick(0, 2'd0, 0, 50);
    tick(1, 2'd3, 64'd777, 0);
    settle();
    chk(time_ns == 777, "R9 set rebases", time_ns, 777);

    // R7: limit
    tick(1, 2'd1, 64'd0, 0);
    tick(1, 2'd1, 64'd65536001, 0);
    settle();
    chk(adj_rej == 1, "R7 over limit rejected", adj_rej, 1);
    tick(1, 2'd3, 64'd0, 0);
    tick(0, 2'd0, 0, 1000);
    settle();
    chk(time_ns == 8000, "R7 multiplier unchanged", time_ns, 8000);
    tick(1, 2'd1, 64'd65536000, 0);
    settle();
    chk(adj_rej == 0, "R7 at limit accepted", adj_rej, 0);

    // R2: unsupported period
    period_ps = 16'd7000;
    settle(); settle();
    chk(cfg_err == 1, "R2 cfg_err", cfg_err, 1);
    begin
      logic [63:0] t0;
      t0 = time_ns;
      repeat (5) tick(0, 2'd0, 0, 100);
      settle();
      chk(time_ns == t0, "R2 time holds", time_ns, t0);
    end
    period_ps = 16'd10000;
    tick(1, 2'd1, 64'd0, 0);

    // random phase
    for (int i = 0; i < 3000; i++) begin
      int unsigned r;
      logic [31:0] inc;
      r = $urandom_range(0, 99);
      inc = ($urandom_range(0, 49) == 0) ? $urandom_range(0, 32'h7FFF_FFFF) : $urandom_range(0, 15);
      if ($urandom_range(0, 99) == 0) begin
        case ($urandom_range(0, 3))
          0: period_ps = 16'd4000;
          1: period_ps = 16'd8000;
          2: period_ps = 16'd10000;
          default: period_ps = 16'd7000;
        endcase
      end
      if (r < 8)       tick(1, 2'd0, 0, inc);
      else if (r < 16) tick(1, 2'd1, 64'(int'($urandom_range(0, 140_000_000)) - 70_000_000), inc);
      else if (r < 20) tick(1, 2'd2, 64'($urandom_range(0, 1 << 20)), inc);
      else if (r < 22) tick(1, 2'd3, {24'd0, 8'($urandom), 32'($urandom)}, inc);
      else             tick(0, 2'd0, 0, inc);
    end
    settle();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule